// File: doc/BRIEF.md
# VLIW Bundle Expander with NOP Refill

This block sits between an instruction fetch path and the issue stage of a six-wide VLIW core. Code is stored in a compact form in which empty issue slots take no space. Each 40-bit operation arrives on a valid/ready stream, one operation per beat. The last operation of an issue group carries a marker bit. The expander collects the operations of one group and places each into a legal lane of a six-lane issue word. It then presents the whole word, with explicit empty lanes, as one registered output beat.

Lanes 0 to 3 are general lanes and accept any operation except a memory access. Lanes 4 and 5 are universal lanes and accept anything. A 2-bit class field marks memory accesses, and those are sent only to universal lanes. Other operations take the general lanes first and spill into the universal lanes once the general lanes are full. A group that does not fit is cut short: every operation that does not fit is discarded, and a sticky error flag is raised.

Top module: `bundle_expander`

## Requirements
- R1: After reset, outValid is 0, errFlag is 0, outSlotValid is all zero and inReady is 1.
- R2: Bit 39 of an operation is the group-end marker. The cycle after an operation with bit 39 set is accepted, outValid is 1 and the output word holds that group.
- R3: An operation whose bits 38:37 equal 2'b10 is a memory access. It is placed only in lanes 4 and 5, and the universal lanes are handed out in order of arrival (lane 4 first), shared with spilled non-memory operations.
- R4: Non-memory operations fill lanes 0, 1, 2, 3 in order of arrival. Once all four are taken, they spill into the next free universal lane.
- R5: Each lane the group does not fill is output as all-zero 40 bits, with its outSlotValid bit at 0.
- R6: An operation that finds no legal free lane is discarded. From the next cycle, errFlag is 1 and stays 1 until reset. The group is still emitted with the operations that did fit.
- R7: While outValid is 1 and outReady is 0, inReady is 0 and the output word and lane-valid bits hold steady. Otherwise inReady is 1.
- R8: The following group starts collecting in the cycle after a group-end operation is accepted. With outReady held at 1, groups sent back to back lose no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation stream valid |
| inOp | input | 40 | Compact operation: bit 39 group end, bits 38:37 class |
| inReady | output | 1 | Operation stream ready |
| outReady | input | 1 | Consumer accepts the issue word |
| outValid | output | 1 | Issue word valid |
| outSlots | output | 240 | Six 40-bit lanes; lane n at bits 40n+39:40n |
| outSlotValid | output | 6 | Per-lane valid, bit n for lane n |
| errFlag | output | 1 | Sticky overflow error |

## Verification
A wrong fill count inside the block shows up on the very next issue word. An operation lands in the wrong lane, an empty lane appears in the middle of lanes 0 to 3, or a memory access sits in a general lane. A lane register that is not cleared leaves a stale operation in an empty lane of the following word. A lost group-end event shows as a missing outValid one cycle after the marker was accepted. The bench keeps its own model of every group, so the word is compared lane by lane in every cycle it is presented, including the cycles it is held under back-pressure.

// File: rtl/bundle_pkg.sv
package bundle_pkg;
  localparam int OP_W       = 40;
  localparam int SLOTS      = 6;
  localparam int UNIV       = 2;
  localparam int GEN        = SLOTS - UNIV;
  localparam int TAIL_BIT   = OP_W - 1;
  localparam int TYPE_HI    = OP_W - 2;
  localparam int TYPE_LO    = OP_W - 3;
  localparam int SLOT_IDX_W = $clog2(SLOTS);
  localparam logic [1:0] MEM_CODE = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic                  wrEn;
    logic [SLOT_IDX_W-1:0] wrSlot;
    logic                  loadOut;
  } ctlStrobe_t;
endpackage

// File: rtl/bundle_ctl.sv
module bundle_ctl
  import bundle_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] opType,
  input  logic       opTail,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output logic       errFlag,
  output ctlStrobe_t strobe
);
  localparam int GCW = $clog2(GEN + 1);
  localparam int UCW = $clog2(UNIV + 1);
  localparam logic [GCW-1:0] GEN_L  = GCW'(GEN);
  localparam logic [UCW-1:0] UNIV_L = UCW'(UNIV);

  logic [GCW-1:0] genCnt;
  logic [UCW-1:0] univCnt;
  logic accept, isMem, useGen, fits;
  logic [SLOT_IDX_W-1:0] slotSel;

  assign inReady = !outValid || outReady;

  always_comb begin
    accept = inValid && inReady;
    isMem  = (opType == MEM_CODE);
    useGen = !isMem && (genCnt < GEN_L);
    fits   = useGen || (univCnt < UNIV_L);
    if (useGen) slotSel = SLOT_IDX_W'(genCnt);
    else        slotSel = SLOT_IDX_W'(GEN) + SLOT_IDX_W'(univCnt);
    strobe.wrEn    = accept && fits;
    strobe.wrSlot  = slotSel;
    strobe.loadOut = accept && opTail;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genCnt   <= '0;
      univCnt  <= '0;
      outValid <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (strobe.loadOut) begin
        genCnt  <= '0;
        univCnt <= '0;
      end else if (strobe.wrEn) begin
        if (useGen) genCnt  <= genCnt + 1'b1;
        else        univCnt <= univCnt + 1'b1;
      end
      if (strobe.loadOut)  outValid <= 1'b1;
      else if (outReady)   outValid <= 1'b0;
      if (accept && !fits) errFlag  <= 1'b1;
    end
  end

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
  assert_count_limit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (genCnt <= GEN_L) && (univCnt <= UNIV_L));
  assert_hold_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);
endmodule

// File: rtl/bundle_dp.sv
module bundle_dp
  import bundle_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            strobe,
  input  logic [OP_W-1:0]       inOp,
  output logic [SLOTS*OP_W-1:0] outSlots,
  output logic [SLOTS-1:0]      outSlotValid
);
  for (genvar g = 0; g < SLOTS; g++) begin : gLane
    logic [OP_W-1:0] accOp, nextOp, outOp;
    logic            accVld, nextVld, wrHit;

    always_comb begin
      wrHit   = strobe.wrEn && (strobe.wrSlot == SLOT_IDX_W'(g));
      nextOp  = wrHit ? inOp : accOp;
      nextVld = wrHit || accVld;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        accOp           <= '0;
        accVld          <= 1'b0;
        outOp           <= '0;
        outSlotValid[g] <= 1'b0;
      end else if (strobe.loadOut) begin
        outOp           <= nextOp;
        outSlotValid[g] <= nextVld;
        accOp           <= '0;
        accVld          <= 1'b0;
      end else begin
        accOp  <= nextOp;
        accVld <= nextVld;
      end
    end

    assign outSlots[g*OP_W +: OP_W] = outOp;
  end
endmodule

// File: rtl/bundle_expander.sv
module bundle_expander
  import bundle_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [OP_W-1:0]       inOp,
  output logic                  inReady,
  input  logic                  outReady,
  output logic                  outValid,
  output logic [SLOTS*OP_W-1:0] outSlots,
  output logic [SLOTS-1:0]      outSlotValid,
  output logic                  errFlag
);
  ctlStrobe_t strobe;

  bundle_ctl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opType   (inOp[TYPE_HI:TYPE_LO]),
    .opTail   (inOp[TAIL_BIT]),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .errFlag  (errFlag),
    .strobe   (strobe)
  );

  bundle_dp uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .inOp         (inOp),
    .outSlots     (outSlots),
    .outSlotValid (outSlotValid)
  );

  logic [GEN-1:0]  genVld;
  logic [UNIV-1:0] univVld;
  assign genVld  = outSlotValid[GEN-1:0];
  assign univVld = outSlotValid[SLOTS-1:GEN];

  // R4: general lanes fill from lane 0 without holes
  assert_gen_prefix_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (((genVld + 1'b1) & genVld) == '0));
  // R3: universal lanes are handed out in order
  assert_univ_prefix_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (((univVld + 1'b1) & univVld) == '0));
  // R7: held word stays put
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> ($stable(outSlots) && $stable(outSlotValid)));

  for (genvar g = 0; g < SLOTS; g++) begin : gChk
    assert_nop_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
      !outSlotValid[g] |-> (outSlots[g*OP_W +: OP_W] == '0));
    if (g < GEN) begin : gGen
      assert_no_mem_general_R3: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && outSlotValid[g]) |->
        (outSlots[g*OP_W + TYPE_HI -: 2] != MEM_CODE));
    end
  end
endmodule

// File: tb/tb_bundle_expander.sv
module tb_bundle_expander;
  import bundle_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [OP_W-1:0] inOp = '0;
  logic inReady;
  logic outReady = 1'b1;
  logic outValid;
  logic [SLOTS*OP_W-1:0] outSlots;
  logic [SLOTS-1:0] outSlotValid;
  logic errFlag;

  always #5 clk = ~clk;

  bundle_expander dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inReady(inReady),
    .outReady(outReady), .outValid(outValid), .outSlots(outSlots),
    .outSlotValid(outSlotValid), .errFlag(errFlag)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int opId = 1;
  bit timedOut = 0;

  logic [OP_W-1:0]       opQ[$];
  logic [SLOTS*OP_W-1:0] expSlotsQ[$];
  logic [SLOTS-1:0]      expVldQ[$];
  logic [OP_W-1:0]       curOps[$];
  int  nTot = 0;
  int  nMem = 0;
  bit  modelErr = 0;

  function automatic logic [OP_W-1:0] mkOp(input bit tail, input bit mem, input int id);
    logic [1:0] typ;
    logic [36:0] payload;
    if (mem) typ = 2'b10;
    else if (id % 3 == 0) typ = 2'b00;
    else if (id % 3 == 1) typ = 2'b01;
    else typ = 2'b11;
    payload = 37'(id) * 37'h1F3A5 + 37'h5;
    return {tail, typ, payload};
  endfunction

  task automatic addPat(input string p);
    for (int i = 0; i < p.len(); i++) begin
      opQ.push_back(mkOp(i == p.len() - 1, p[i] == "m", opId));
      opId++;
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [OP_W-1:0] act, input logic [OP_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // builds the expected issue word from the operations that fit
  task automatic closeBundle();
    logic [SLOTS*OP_W-1:0] s;
    logic [SLOTS-1:0] v;
    int gi, ui, idx;
    s = '0; v = '0; gi = 0; ui = 0;
    foreach (curOps[k]) begin
      if (curOps[k][38:37] == 2'b10 || gi >= 4) begin
        idx = 4 + ui; ui++;
      end else begin
        idx = gi; gi++;
      end
      s[idx*OP_W +: OP_W] = curOps[k];
      v[idx] = 1'b1;
    end
    expSlotsQ.push_back(s);
    expVldQ.push_back(v);
    curOps.delete();
    nTot = 0; nMem = 0;
  endtask

  task automatic step(input logic v, input logic [OP_W-1:0] op, input logic rdy,
                      output bit took);
    bit isMem, fitsOp, setErr;
    @(negedge clk);
    inValid = v; inOp = op; outReady = rdy;
    #1;
    cyc++;
    // R2: word present exactly when a closed group is pending
    check(outValid == (expSlotsQ.size() > 0), "R2", "outValid", 40'(outValid),
          40'(expSlotsQ.size() > 0));
    // R6: sticky error
    check(errFlag == modelErr, "R6", "errFlag", 40'(errFlag), 40'(modelErr));
    // R7: ready only drops while a word is held
    check(inReady == (!outValid || rdy), "R7", "inReady", 40'(inReady),
          40'(!outValid || rdy));
    if (outValid && expSlotsQ.size() > 0) begin
      for (int s = 0; s < SLOTS; s++) begin
        string tag;
        logic ev;
        logic [OP_W-1:0] eo;
        ev = expVldQ[0][s];
        eo = expSlotsQ[0][s*OP_W +: OP_W];
        if (!ev) tag = "R5";
        else if (s < GEN) tag = "R4";
        else tag = "R3";
        check((outSlotValid[s] == ev) && (outSlots[s*OP_W +: OP_W] === eo), tag,
              $sformatf("lane %0d valid=%0b", s, outSlotValid[s]),
              outSlots[s*OP_W +: OP_W], eo);
      end
    end
    if (outValid && rdy && expSlotsQ.size() > 0) begin
      void'(expSlotsQ.pop_front());
      void'(expVldQ.pop_front());
    end
    took = v && inReady;
    setErr = 0;
    if (took) begin
      isMem = (op[38:37] == 2'b10);
      fitsOp = isMem ? (nMem < 2 && nTot < 6) : (nTot < 6);
      if (fitsOp) begin
        curOps.push_back(op);
        nTot++;
        if (isMem) nMem++;
      end else setErr = 1;
      if (op[39]) closeBundle();
    end
    if (setErr) modelErr = 1;
  endtask

  task automatic runPhase(input bit gaps, input bit slowReady);
    bit took;
    logic v, rdy;
    while (!timedOut && (opQ.size() > 0 || expSlotsQ.size() > 0)) begin
      v = (opQ.size() > 0) && !(gaps && (cyc % 3 == 1));
      rdy = slowReady ? (cyc % 4 == 3) : 1'b1;
      step(v, v ? opQ[0] : '0, rdy, took);
      if (took) void'(opQ.pop_front());
      if (cyc > 20000) begin
        timedOut = 1;
        failures++;
        $display("FAIL R2 watchdog expired actual=%0d expected<=%0d", cyc, 20000);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    check(outValid == 1'b0, "R1", "outValid", 40'(outValid), 40'd0);
    check(errFlag == 1'b0, "R1", "errFlag", 40'(errFlag), 40'd0);
    check(inReady == 1'b1, "R1", "inReady", 40'(inReady), 40'd1);
    check(outSlotValid == '0, "R1", "outSlotValid", 40'(outSlotValid), 40'd0);

    // R8: back-to-back groups, consumer always ready
    addPat("n");
    addPat("mnnmnn");
    addPat("nnnnnn");
    addPat("mnnnnn");
    addPat("m");
    addPat("nn");
    addPat("nnnnnm");
    runPhase(0, 0);

    // R7: gaps on the input and a slow consumer
    addPat("nmn");
    addPat("mm");
    addPat("nnnnm");
    addPat("n");
    runPhase(1, 1);

    // R6: overflow cases, then normal traffic with the flag still set
    addPat("mmm");
    addPat("nnnnnnn");
    addPat("nnnnnmm");
    addPat("mn");
    runPhase(0, 1);
    addPat("nnm");
    runPhase(0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule